// File: doc/BRIEF.md
# Conversion-Complete Interrupt Flag and Vector Unit

This block collects the interrupt sources of a multi-slot converter and turns them into one request line and one numeric vector. There are eighteen sources. Sixteen are per-slot completion flags: each one is set when the sequencer loads a result into its slot, and cleared when the bus reads that slot. The other two are error flags. The result-overwrite flag is set when a slot is written while its completion flag is still set, because the earlier result was lost unread. The timing-overflow flag is set when a new sample request arrives before the running conversion has finished.

Each source has an enable bit. A flag is always recorded, but it asks for service only while its enable bit is 1. The vector names the highest-priority source that is both pending and enabled. Result-overwrite ranks highest, then timing overflow, then slots 0 through 15. When software reads the vector, the error flag that the vector reports is cleared. Slot flags are cleared only by reading their slots.

Top module: `cvt_irq_hub`

## Requirements
- R1: While reset is asserted, and after it is released, every slot flag and both error flags are 0, `irq` is 0 and `vec` is 0.
- R2: A 1 on `slot_wr[n]` sets `slot_flags[n]` at the next clock edge.
- R3: A 1 on `slot_rd[n]` with `slot_wr[n]` low clears `slot_flags[n]` at the next edge. If write and read hit the same slot in the same cycle, the write wins and the flag is 1.
- R4: `ovf_flag` is set at the next edge when some slot n has `slot_wr[n]`=1, `slot_flags[n]`=1 and `slot_rd[n]`=0. In that case the slot flag stays 1.
- R5: `tmo_evt`=1 sets `tmo_flag` at the next edge.
- R6: Flags are recorded whatever the enables are. A flag takes part in `irq` and `vec` only while its enable (`slot_en[n]`, `ovf_en` or `tmo_en`) is 1.
- R7: `vec` is combinational from the current flags and enables. It is 2 for an enabled result-overwrite, else 4 for an enabled timing overflow, else 6+2n for the lowest-numbered enabled pending slot n, else 0.
- R8: `vec_rd`=1 while `vec`=2 clears `ovf_flag`, and while `vec`=4 it clears `tmo_flag`, at the next edge. A set condition (R4 or R5) in that same cycle wins and keeps the flag at 1.
- R9: `vec_rd`=1 while `vec` reports a slot (6 or more) leaves every slot flag unchanged.
- R10: `irq` is 1 exactly when `vec` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| slot_wr | input | 16 | Per-slot result-load strobes from the sequencer |
| slot_rd | input | 16 | Per-slot result-read strobes from the bus |
| tmo_evt | input | 1 | Sample request arrived during a conversion |
| vec_rd | input | 1 | Vector read strobe |
| slot_en | input | 16 | Per-slot interrupt enables |
| ovf_en | input | 1 | Result-overwrite interrupt enable |
| tmo_en | input | 1 | Timing-overflow interrupt enable |
| slot_flags | output | 16 | Slot completion flags |
| ovf_flag | output | 1 | Result-overwrite flag |
| tmo_flag | output | 1 | Timing-overflow flag |
| irq | output | 1 | Interrupt request |
| vec | output | 6 | Priority-encoded vector |

## Verification
The hardest situation to reach from the ports is a vector read that would clear an error flag landing in the same cycle as a fresh overwrite or timing event. A close second is a write and a read arriving together on a slot whose flag is already set. Both need several conditions to line up in one cycle. The random stimulus therefore writes densely over a few slots, so flags stay set and overwrites are common. It also issues vector reads and timing events at high rates. Directed steps then force each of these collisions at least once.

// File: rtl/cvt_irq_pkg.sv
package cvt_irq_pkg;
  localparam int unsigned CODE_NONE      = 0;
  localparam int unsigned CODE_OVF       = 2;
  localparam int unsigned CODE_TMO       = 4;
  localparam int unsigned CODE_SLOT_BASE = 6;
  localparam int unsigned CODE_STEP      = 2;

  function automatic int unsigned slot_code(input int unsigned n);
    return CODE_SLOT_BASE + CODE_STEP * n;
  endfunction

  function automatic int unsigned code_width(input int unsigned nslot);
    return $clog2(slot_code(nslot - 1) + 1);
  endfunction
endpackage

// File: rtl/cvt_slot_flags.sv
module cvt_slot_flags #(
  parameter int unsigned NSLOT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] wr_i,
  input  logic [NSLOT-1:0] rd_i,
  output logic [NSLOT-1:0] flag_o,
  output logic             clash_o
);
  logic [NSLOT-1:0] flag_q;

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      logic bit_q;
      logic bit_d;
      logic bit_en;

      // next state: any strobe updates, write dominates read
      always_comb begin
        bit_en = wr_i[g] | rd_i[g];
        bit_d  = wr_i[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bit_q <= 1'b0;
        else if (bit_en) bit_q <= bit_d;
      end

      assign flag_q[g] = bit_q;
    end
  endgenerate

  assign flag_o  = flag_q;
  // a load onto an unread result that is not being read now loses data
  assign clash_o = |(wr_i & flag_q & ~rd_i);
endmodule

// File: rtl/cvt_err_flag.sv
module cvt_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cvt_vec_enc.sv
module cvt_vec_enc
  import cvt_irq_pkg::*;
#(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned VW    = code_width(NSLOT)
) (
  input  logic [NSLOT-1:0] slot_pend_i,
  input  logic             ovf_pend_i,
  input  logic             tmo_pend_i,
  output logic [VW-1:0]    code_o,
  output logic             any_o
);
  always_comb begin
    code_o = VW'(CODE_NONE);
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slot_pend_i[i]) code_o = VW'(slot_code(i));
    end
    if (tmo_pend_i) code_o = VW'(CODE_TMO);
    if (ovf_pend_i) code_o = VW'(CODE_OVF);
  end

  assign any_o = ovf_pend_i | tmo_pend_i | (|slot_pend_i);
endmodule

// File: rtl/cvt_irq_hub.sv
module cvt_irq_hub
  import cvt_irq_pkg::*;
#(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned VW    = code_width(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] slot_wr,
  input  logic [NSLOT-1:0] slot_rd,
  input  logic             tmo_evt,
  input  logic             vec_rd,
  input  logic [NSLOT-1:0] slot_en,
  input  logic             ovf_en,
  input  logic             tmo_en,
  output logic [NSLOT-1:0] slot_flags,
  output logic             ovf_flag,
  output logic             tmo_flag,
  output logic             irq,
  output logic [VW-1:0]    vec
);
  logic [1:0]       rsync_q;
  logic             rst_sync_n;
  logic             clash;
  logic [NSLOT-1:0] flags_w;
  logic             ovf_w;
  logic             tmo_w;
  logic [VW-1:0]    code_w;
  logic             any_w;
  logic             ovf_clr;
  logic             tmo_clr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  cvt_slot_flags #(.NSLOT(NSLOT)) u_slots (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_i   (slot_wr),
    .rd_i   (slot_rd),
    .flag_o (flags_w),
    .clash_o(clash)
  );

  assign ovf_clr = vec_rd && (code_w == VW'(CODE_OVF));
  assign tmo_clr = vec_rd && (code_w == VW'(CODE_TMO));

  cvt_err_flag u_ovf (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (clash),
    .clr_i (ovf_clr),
    .flag_o(ovf_w)
  );

  cvt_err_flag u_tmo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (tmo_evt),
    .clr_i (tmo_clr),
    .flag_o(tmo_w)
  );

  cvt_vec_enc #(.NSLOT(NSLOT), .VW(VW)) u_enc (
    .slot_pend_i(flags_w & slot_en),
    .ovf_pend_i (ovf_w & ovf_en),
    .tmo_pend_i (tmo_w & tmo_en),
    .code_o     (code_w),
    .any_o      (any_w)
  );

  assign slot_flags = flags_w;
  assign ovf_flag   = ovf_w;
  assign tmo_flag   = tmo_w;
  assign irq        = any_w;
  assign vec        = code_w;
endmodule

// File: rtl/cvt_irq_hub_chk.sv
module cvt_irq_hub_chk #(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned VW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSLOT-1:0] slot_wr,
  input logic [NSLOT-1:0] slot_rd,
  input logic             tmo_evt,
  input logic             vec_rd,
  input logic             ovf_en,
  input logic [NSLOT-1:0] slot_flags,
  input logic             ovf_flag,
  input logic             irq,
  input logic             tmo_flag,
  input logic [VW-1:0]    vec
);
  assert_wr_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wr != '0) |=> ((slot_flags & $past(slot_wr)) == $past(slot_wr)));

  assert_rd_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_rd & ~slot_wr) != '0) |=> ((slot_flags & $past(slot_rd & ~slot_wr)) == '0));

  assert_overwrite_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_wr & slot_flags & ~slot_rd) != '0) |=> ovf_flag);

  assert_tmo_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> tmo_flag);

  assert_vec_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec[0] == 1'b0);

  assert_vec_ovf_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec == VW'(2)) |-> (ovf_flag && ovf_en));

  assert_vecrd_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec == VW'(2) && (slot_wr & slot_flags & ~slot_rd) == '0) |=> !ovf_flag);

  assert_vecrd_keeps_slots_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec >= VW'(6) && slot_rd == '0)
      |=> ((slot_flags & $past(slot_flags)) == $past(slot_flags)));

  assert_irq_matches_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (vec != '0));
endmodule

bind cvt_irq_hub cvt_irq_hub_chk #(.NSLOT(NSLOT), .VW(VW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .slot_wr   (slot_wr),
  .slot_rd   (slot_rd),
  .tmo_evt   (tmo_evt),
  .vec_rd    (vec_rd),
  .ovf_en    (ovf_en),
  .slot_flags(slot_flags),
  .ovf_flag  (ovf_flag),
  .irq       (irq),
  .tmo_flag  (tmo_flag),
  .vec       (vec)
);

// File: tb/sim_cvt_irq_hub.sv
module sim_cvt_irq_hub;
  localparam int unsigned NS = 16;
  localparam int unsigned VW = cvt_irq_pkg::code_width(NS);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] slot_wr, slot_rd, slot_en;
  logic          tmo_evt, vec_rd, ovf_en, tmo_en;
  logic [NS-1:0] slot_flags;
  logic          ovf_flag, tmo_flag, irq;
  logic [VW-1:0] vec;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  logic [NS-1:0] m_flags;
  logic          m_ovf, m_tmo;

  always #5 clk = ~clk;

  cvt_irq_hub u0 (
    .clk(clk), .rst_n(rst_n), .slot_wr(slot_wr), .slot_rd(slot_rd),
    .tmo_evt(tmo_evt), .vec_rd(vec_rd), .slot_en(slot_en), .ovf_en(ovf_en),
    .tmo_en(tmo_en), .slot_flags(slot_flags), .ovf_flag(ovf_flag),
    .tmo_flag(tmo_flag), .irq(irq), .vec(vec)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R7 priority model
  function automatic int unsigned exp_vec();
    if (m_ovf && ovf_en) return 2;
    if (m_tmo && tmo_en) return 4;
    for (int i = 0; i < NS; i++)
      if (m_flags[i] && slot_en[i]) return 6 + 2 * i;
    return 0;
  endfunction

  task automatic tick(input logic [NS-1:0] wr, input logic [NS-1:0] rd,
                      input logic te, input logic vr);
    int unsigned ev;
    logic [NS-1:0] nf;
    logic no, nt;
    slot_wr = wr; slot_rd = rd; tmo_evt = te; vec_rd = vr;
    #1;
    ev = exp_vec();
    chk("R2/R3 slot flags", 64'(slot_flags), 64'(m_flags));
    chk("R4 overwrite flag", 64'(ovf_flag), 64'(m_ovf));
    chk("R5 timing flag", 64'(tmo_flag), 64'(m_tmo));
    chk("R7 vector", 64'(vec), 64'(ev));
    chk("R6 irq", 64'(irq), 64'(ev != 0));
    chk("R10 irq vs vec", 64'(irq), 64'(vec != '0));
    nf = (m_flags & ~rd) | wr;
    no = m_ovf; nt = m_tmo;
    if (vr && ev == 2) no = 1'b0;     // R8
    if (vr && ev == 4) nt = 1'b0;     // R8
    if ((wr & m_flags & ~rd) != '0) no = 1'b1;
    if (te) nt = 1'b1;
    @(posedge clk);
    m_flags = nf; m_ovf = no; m_tmo = nt;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; slot_wr = '0; slot_rd = '0; tmo_evt = 1'b0; vec_rd = 1'b0;
    slot_en = '1; ovf_en = 1'b1; tmo_en = 1'b1;
    m_flags = '0; m_ovf = 1'b0; m_tmo = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1 flags in reset", 64'({slot_flags, ovf_flag, tmo_flag}), 64'(0));
    chk("R1 irq in reset", 64'(irq), 64'(0));
    chk("R1 vec in reset", 64'(vec), 64'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 state after release", 64'({slot_flags, ovf_flag, tmo_flag, irq, vec}), 64'(0));

    tick(16'h0008, '0, 0, 0);             // R2 slot 3 -> vec 12
    tick(16'h8001, '0, 0, 0);             // R2, R7 slot 0 outranks
    tick('0, 16'h0001, 0, 0);             // R3 read slot 0
    tick(16'h0008, 16'h0008, 0, 0);       // R3 write wins, no overwrite
    tick('0, '0, 0, 0);
    chk("R4 no overwrite on write+read", 64'(ovf_flag), 64'(0));
    tick(16'h0008, '0, 0, 0);             // R4 overwrite slot 3
    tick('0, '0, 1, 0);                   // R5
    chk("R7 overwrite outranks timing", 64'(vec), 64'(2));
    tick('0, '0, 0, 1);                   // R8 clear overwrite
    chk("R8 vec after overwrite cleared", 64'(vec), 64'(4));
    tick('0, '0, 0, 1);                   // R8 clear timing
    tick('0, '0, 0, 1);                   // R9 vec read on slot code
    chk("R9 slot flags kept", 64'(slot_flags), 64'(16'h8008));
    tick(16'h0008, '0, 0, 0);             // new overwrite
    tick(16'h8000, '0, 1, 1);             // R8 clear collides with both sets
    tick('0, '0, 0, 0);
    chk("R8 set wins over vec read", 64'({ovf_flag, tmo_flag}), 64'(2'b11));
    slot_en = '0; ovf_en = 1'b0; tmo_en = 1'b0;
    tick('0, '0, 0, 0);                   // R6 all masked
    chk("R6 masked irq", 64'(irq), 64'(0));
    chk("R6 flags still held", 64'({slot_flags, ovf_flag, tmo_flag}), 64'({16'h8008, 2'b11}));
    tick('0, '0, 0, 1);                   // vec 0: read must not clear
    slot_en = 16'h8000;
    tick('0, '0, 0, 0);
    chk("R6 only enabled slot seen", 64'(vec), 64'(36));

    for (int k = 0; k < 4000; k++) begin
      logic [NS-1:0] w, r;
      if (k % 50 == 0) begin
        slot_en = NS'($urandom); ovf_en = 1'($urandom); tmo_en = 1'($urandom);
      end
      w = NS'($urandom & $urandom & 32'h0000_00F3);
      r = NS'($urandom & $urandom & $urandom);
      tick(w, r, ($urandom % 6) == 0, ($urandom % 3) == 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule